// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Qualified Reload

A bank of pulse-width-modulated outputs. Each output is shaped by its own clock divider, period length and active length, plus an inversion bit. Software writes new values into staging registers through a plain write strobe. The running waveform keeps using its active copy until software sends a qualified reload pulse for that channel.

Reload pulses come from one trigger bit per channel in a shared control word. A pulse counts only if the trigger was low for a minimum time before it rose and then stayed high for that same minimum time. The minimum time is `MIN_HOLD_CYC` clock cycles; the default of 50 cycles is 400 ns at 125 MHz. A companion smooth bit in the same word decides when a qualified reload takes hold. When the bit is clear the reload applies at once. When it is set the reload waits for the end of the period that is running. A channel is switched off by loading zero prescale, zero period and zero duty, which holds the pin at its inactive level.

Top module: `trig_pwm_bank`

## Requirements
- R1: Synchronous active-low reset clears every register to zero and drives every `pwm_out` bit low.
- R2: Register map. Address 0 is control, address 1 is prescale, addresses 2..5 are the period counts of channels 0..3, and addresses 6..9 are their duty counts. Control bit i is the trigger of channel i, bit 4+i is its smooth bit and bit 8+i is its inversion bit. In the prescale word, channel i owns bits [4i+3:4i]. A read returns the value written, which for settings is the staged value.
- R3: With active prescale p, period n>0 and duty d, the waveform repeats every (p+1)*n cycles and is active for (p+1)*min(d,n) cycles of each repeat. Each reload restarts the waveform at the start of a period.
- R4: When the inversion bit is 1 at reload, the pin carries the complement of the active level.
- R5: Writing staging registers while no qualified trigger pulse occurs leaves the output waveform unchanged.
- R6: A trigger that stays high for fewer than `MIN_HOLD_CYC` cycles causes no reload. A trigger held high longer causes exactly one reload.
- R7: A trigger that rises after being low for fewer than `MIN_HOLD_CYC` cycles causes no reload, however long it then stays high.
- R8: When the smooth bit is 0 as a reload qualifies, the staged prescale, period, duty and inversion values become active immediately.
- R9: When the smooth bit is 1 as a reload qualifies, the staged values become active only at the end of the current period. They are sampled at that moment.
- R10: With active period 0 the pin holds its inactive level, which is 0 when not inverted and 1 when inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| pwm_out | output | NCH | One PWM pin per channel |

## Verification
The waveform is measured by counting active cycles over a window that spans a whole number of periods. These windows cover a short duty, a duty equal to the period, a duty beyond the period, zero duty, a divided clock with inversion, and two disabled channels of opposite polarity. Each count separates a wrong divider, a wrong compare or a wrong inversion from the correct one. For reloads, the bench sends a trigger pulse that is too short and a pulse raised after a gap that is too short, and follows each with a valid pulse. This shows that the staged values were correct and that only the timing rule blocked them. A long-period, always-active channel reloaded to zero duty shows apart a deferred reload, where the pin is still high mid-period, from an immediate one, where it drops at once.

// File: rtl/trig_pwm_pkg.sv
// Shared constants and types for the PWM bank.
// Assumes the address map below fits inside the chosen address width.
package trig_pwm_pkg;

    localparam int unsigned CTRL_ADDR  = 0;
    localparam int unsigned PRESC_ADDR = 1;
    localparam int unsigned PER_BASE   = 2;

    // Trigger qualifier states
    typedef enum logic [1:0] {
        TQ_LOW   = 2'd0,   // trigger low, measuring gap
        TQ_ARMED = 2'd1,   // trigger high after a long enough gap
        TQ_SPENT = 2'd2    // trigger high, no further load possible
    } tq_state_e;

endpackage

// File: rtl/trig_pwm_regs.sv
// Register file: control word, shared prescale word, per-channel period and
// duty staging registers. Reads are combinational from rd_addr.
// Assumes 2 + 2*NCH addresses fit in ADDR_W and all fields fit in DATA_W.
module trig_pwm_regs
    import trig_pwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int PRE_W  = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    output logic [3*NCH-1:0]       ctrl_q,
    output logic [NCH*PRE_W-1:0]   presc_q,
    output logic [NCH*CNT_W-1:0]   per_q,
    output logic [NCH*CNT_W-1:0]   duty_q
);
    localparam int CTRL_W    = 3 * NCH;
    localparam int PRESC_W   = NCH * PRE_W;
    localparam int DUTY_BASE = PER_BASE + NCH;

    logic [CNT_W-1:0] per_r  [NCH];
    logic [CNT_W-1:0] duty_r [NCH];

    // Control word write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
            ctrl_q <= wr_data[CTRL_W-1:0];
    end

    // Shared prescale word write
    always_ff @(posedge clk) begin
        if (!rst_n)
            presc_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(PRESC_ADDR))
            presc_q <= wr_data[PRESC_W-1:0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_stage
        // Per-channel period staging write
        always_ff @(posedge clk) begin
            if (!rst_n)
                per_r[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(PER_BASE + i))
                per_r[i] <= wr_data[CNT_W-1:0];
        end

        // Per-channel duty staging write
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_r[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(DUTY_BASE + i))
                duty_r[i] <= wr_data[CNT_W-1:0];
        end

        assign per_q[i*CNT_W +: CNT_W]  = per_r[i];
        assign duty_q[i*CNT_W +: CNT_W] = duty_r[i];
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_ADDR))
            rd_data[CTRL_W-1:0] = ctrl_q;
        else if (rd_addr == ADDR_W'(PRESC_ADDR))
            rd_data[PRESC_W-1:0] = presc_q;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(PER_BASE + i))
                rd_data[CNT_W-1:0] = per_r[i];
            if (rd_addr == ADDR_W'(DUTY_BASE + i))
                rd_data[CNT_W-1:0] = duty_r[i];
        end
    end

endmodule

// File: rtl/trig_pwm_qual.sv
// Trigger qualifier for one channel. Emits a one-cycle load request once the
// trigger has been high for MIN_HOLD_CYC cycles, provided it was low for at
// least MIN_HOLD_CYC cycles before rising. Assumes MIN_HOLD_CYC >= 2.
module trig_pwm_qual
    import trig_pwm_pkg::*;
#(
    parameter int MIN_HOLD_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic load_o
);
    localparam int CW = $clog2(MIN_HOLD_CYC + 1);
    localparam logic [CW-1:0] LIM      = CW'(MIN_HOLD_CYC);
    localparam logic [CW-1:0] HIGH_END = CW'(MIN_HOLD_CYC - 1);

    tq_state_e     state;
    logic [CW-1:0] cnt;

    // Gap / hold measurement and load pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TQ_LOW;
            cnt    <= '0;
            load_o <= 1'b0;
        end else begin
            load_o <= 1'b0;
            unique case (state)
                TQ_LOW: begin
                    if (trig_i) begin
                        state <= (cnt >= LIM) ? TQ_ARMED : TQ_SPENT;
                        cnt   <= CW'(1);
                    end else if (cnt < LIM) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TQ_ARMED: begin
                    if (!trig_i) begin
                        state <= TQ_LOW;
                        cnt   <= CW'(1);
                    end else if (cnt == HIGH_END) begin
                        load_o <= 1'b1;
                        state  <= TQ_SPENT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (!trig_i) begin
                        state <= TQ_LOW;
                        cnt   <= CW'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/trig_pwm_chan.sv
// One PWM channel: active settings, prescaler, period counter and output
// stage. A load either applies at once or, with smooth set, waits for the end
// of the current period; staged values are sampled when the load applies.
// A zero period holds the pin at the inactive level.
module trig_pwm_chan #(
    parameter int PRE_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             smooth_i,
    input  logic             pol_i,
    input  logic [PRE_W-1:0] stg_pre_i,
    input  logic [CNT_W-1:0] stg_per_i,
    input  logic [CNT_W-1:0] stg_duty_i,
    output logic             pwm_o,
    output logic             apply_o,
    output logic             pend_o
);
    logic [PRE_W-1:0] act_pre, pre_cnt;
    logic [CNT_W-1:0] act_per, act_duty, cnt;
    logic             act_pol;
    logic             tick, per_zero, wrap, period_end;

    assign tick       = (pre_cnt == act_pre);
    assign per_zero   = (act_per == '0);
    assign wrap       = tick && (cnt >= act_per - 1'b1);
    assign period_end = per_zero || wrap;
    assign apply_o    = (load_i && (!smooth_i || period_end)) || (pend_o && period_end);

    // Active settings, pending flag and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre  <= '0;
            act_per  <= '0;
            act_duty <= '0;
            act_pol  <= 1'b0;
            pre_cnt  <= '0;
            cnt      <= '0;
            pend_o   <= 1'b0;
        end else if (apply_o) begin
            act_pre  <= stg_pre_i;
            act_per  <= stg_per_i;
            act_duty <= stg_duty_i;
            act_pol  <= pol_i;
            pre_cnt  <= '0;
            cnt      <= '0;
            pend_o   <= 1'b0;
        end else begin
            if (load_i)
                pend_o <= 1'b1;
            if (per_zero) begin
                pre_cnt <= '0;
                cnt     <= '0;
            end else if (tick) begin
                pre_cnt <= '0;
                cnt     <= wrap ? '0 : cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // Registered output with inversion
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_o <= 1'b0;
        else
            pwm_o <= act_pol ^ (!per_zero && (cnt < act_duty));
    end

endmodule

// File: rtl/trig_pwm_bank.sv
// Top of the PWM bank: register file, one trigger qualifier and one channel
// per output. Control word bit i is the trigger, NCH+i the smooth bit and
// 2*NCH+i the inversion bit of channel i.
module trig_pwm_bank #(
    parameter int NCH          = 4,
    parameter int PRE_W        = 4,
    parameter int CNT_W        = 16,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 4,
    parameter int MIN_HOLD_CYC = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    pwm_out
);
    logic [3*NCH-1:0]     ctrl_q;
    logic [NCH*PRE_W-1:0] presc_q;
    logic [NCH*CNT_W-1:0] per_q;
    logic [NCH*CNT_W-1:0] duty_q;
    logic [NCH-1:0]       load_req;
    logic [NCH-1:0]       applied;
    logic [NCH-1:0]       pend;

    trig_pwm_regs #(
        .NCH(NCH), .PRE_W(PRE_W), .CNT_W(CNT_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl_q(ctrl_q), .presc_q(presc_q), .per_q(per_q), .duty_q(duty_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        trig_pwm_qual #(.MIN_HOLD_CYC(MIN_HOLD_CYC)) u_qual (
            .clk(clk), .rst_n(rst_n),
            .trig_i(ctrl_q[i]),
            .load_o(load_req[i])
        );

        trig_pwm_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .load_i(load_req[i]),
            .smooth_i(ctrl_q[NCH + i]),
            .pol_i(ctrl_q[2*NCH + i]),
            .stg_pre_i(presc_q[i*PRE_W +: PRE_W]),
            .stg_per_i(per_q[i*CNT_W +: CNT_W]),
            .stg_duty_i(duty_q[i*CNT_W +: CNT_W]),
            .pwm_o(pwm_out[i]),
            .apply_o(applied[i]),
            .pend_o(pend[i])
        );
    end

endmodule

// File: rtl/trig_pwm_bank_chk.sv
// Assertion checker for the PWM bank, bound to every instance of the top.
module trig_pwm_bank_chk #(
    parameter int NCH    = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [3*NCH-1:0]  ctrl_q,
    input logic [NCH-1:0]    load_req,
    input logic [NCH-1:0]    applied,
    input logic [NCH-1:0]    pend
);
    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (ctrl_q == $past(wr_data[3*NCH-1:0])));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R6
        load_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_req[i] |-> (ctrl_q[i] && $past(ctrl_q[i])));

        // R6
        single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_req[i] |=> !load_req[i]);

        // R8
        direct_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_req[i] && !ctrl_q[NCH + i]) |-> applied[i]);

        // R9
        defer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_req[i] && !applied[i]) |=> pend[i]);

        // R5
        apply_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            applied[i] |-> (load_req[i] || pend[i]));
    end

endmodule

bind trig_pwm_bank trig_pwm_bank_chk #(
    .NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/trig_pwm_bank_tb.sv
module trig_pwm_bank_tb;
    localparam int NCH = 4;
    localparam int MIN = 50;
    localparam int NV  = 8;
    // Vector fields: channel, prescale, period, duty, invert, window, expected active count
    localparam int VEC [NV][7] = '{
        '{0, 0, 8, 2, 0, 32, 8},
        '{1, 1, 10, 3, 0, 80, 24},
        '{2, 2, 5, 5, 0, 60, 60},
        '{3, 0, 6, 9, 0, 24, 24},
        '{0, 3, 4, 1, 1, 64, 48},
        '{1, 0, 7, 0, 0, 28, 0},
        '{2, 0, 0, 0, 1, 40, 40},
        '{3, 0, 0, 0, 0, 40, 0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [NCH-1:0] pwm_out;

    int errors = 0;
    int checks = 0;
    logic [31:0] ctrl_sh = '0;
    logic [31:0] presc_sh = '0;

    trig_pwm_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        rd_addr = 4'(addr);
        #1 data = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input int ch, input bit trig, input bit smooth, input bit inv);
        ctrl_sh[ch] = trig;
        ctrl_sh[4 + ch] = smooth;
        ctrl_sh[8 + ch] = inv;
        wr(0, ctrl_sh);
    endtask

    task automatic count_high(input int ch, input int win, output int n);
        n = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) n++;
        end
    endtask

    // Stage settings behind a low trigger, then reload immediately
    task automatic program_ch(input int ch, input int pre, input int per, input int duty, input bit inv);
        set_ctrl(ch, 1'b0, 1'b1, ctrl_sh[8 + ch]);
        wait_cyc(MIN + 5);
        presc_sh[ch*4 +: 4] = 4'(pre);
        wr(1, presc_sh);
        wr(2 + ch, 32'(per));
        wr(6 + ch, 32'(duty));
        set_ctrl(ch, 1'b1, 1'b0, inv);
        wait_cyc(MIN + 10);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int n;
        wait_cyc(4);
        #1;
        // R1: reset state
        chk("R1 pwm_out", int'(pwm_out), 0);
        rst_n = 1'b1;
        rd(0, d); chk("R1 ctrl", int'(d), 0);
        rd(2, d); chk("R1 period0", int'(d), 0);
        chk("R1 pwm_out after reset", int'(pwm_out), 0);

        // R2: staged readback
        wr(4, 32'h1234);
        rd(4, d); chk("R2 period2 readback", int'(d), 32'h1234);
        wr(7, 32'h00ab);
        rd(7, d); chk("R2 duty1 readback", int'(d), 32'h00ab);
        presc_sh = 32'h0000_5a30;
        wr(1, presc_sh);
        rd(1, d); chk("R2 prescale readback", int'(d), 32'h5a30);
        presc_sh = '0;
        wr(1, presc_sh);

        // R3 R4 R10: waveform table
        for (int v = 0; v < NV; v++) begin
            program_ch(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4] != 0);
            count_high(VEC[v][0], VEC[v][5], n);
            chk($sformatf("R3/R4/R10 vector %0d", v), n, VEC[v][6]);
        end
        rd(0, d); chk("R2 ctrl readback", int'(d), int'(ctrl_sh));

        // R5: staging with trigger low leaves ch0 running (pre0 per8 duty2)
        program_ch(0, 0, 8, 2, 1'b0);
        set_ctrl(0, 1'b0, 1'b1, 1'b0);
        wr(2, 32'd20);
        wr(6, 32'd15);
        wait_cyc(MIN + 5);
        count_high(0, 32, n);
        chk("R5 staged values not applied", n, 8);

        // R6: high pulse too short
        set_ctrl(0, 1'b1, 1'b0, 1'b0);
        wait_cyc(10);
        set_ctrl(0, 1'b0, 1'b0, 1'b0);
        wait_cyc(10);
        // R7: rise after too short a gap, then long high
        set_ctrl(0, 1'b1, 1'b0, 1'b0);
        wait_cyc(MIN + 10);
        count_high(0, 32, n);
        chk("R6/R7 short pulse and short gap ignored", n, 8);

        // R6: valid pulse loads the staged per20 duty15
        set_ctrl(0, 1'b0, 1'b0, 1'b0);
        wait_cyc(MIN + 5);
        set_ctrl(0, 1'b1, 1'b0, 1'b0);
        wait_cyc(MIN + 10);
        count_high(0, 80, n);
        chk("R6 valid pulse loads", n, 60);

        // R9: smooth reload waits for period end (ch1 always active, period 250)
        program_ch(1, 0, 250, 250, 1'b0);
        set_ctrl(1, 1'b0, 1'b1, 1'b0);
        wait_cyc(MIN + 5);
        wr(7, 32'd0);
        set_ctrl(1, 1'b1, 1'b1, 1'b0);
        wait_cyc(MIN + 20);
        chk("R9 deferred, still active mid-period", int'(pwm_out[1]), 1);
        wait_cyc(150);
        chk("R9 applied after period end", int'(pwm_out[1]), 0);

        // R8: immediate reload mid-period
        set_ctrl(1, 1'b0, 1'b1, 1'b0);
        wait_cyc(MIN + 5);
        wr(7, 32'd250);
        set_ctrl(1, 1'b1, 1'b0, 1'b0);
        wait_cyc(MIN + 10);
        chk("R8 immediate apply", int'(pwm_out[1]), 1);

        finish_run();
    end

endmodule